// File: doc/BRIEF.md
# Configuration Image Byte Loader

This block takes a fixed-length configuration image from a host processor, one byte per bus write, and passes each accepted byte on to internal configuration storage together with its position in the image. The host talks to it over a small register bus with a shared address, a write strobe, write data and combinational read data. A ready flag paces the host. After each accepted byte the flag stays low for a short, configurable interval, which stands for the internal write. The host polls the flag before each byte.

A running CRC-16 is kept over every accepted byte. The polynomial is 0x1021, the seed is 0xFFFF, and each byte is processed most significant bit first. The image carries its own expected CRC in its last two bytes, high byte first, so a clean image leaves a zero residue. When the final byte of the 10,496-byte image is accepted, the block raises a completion flag and latches a pass/fail verdict. Both flags then hold until reset. A readable byte counter shows progress at any time. If a load fails, the host asserts reset and runs the whole load again.

Top module: `cfg_image_loader`

## Requirements
- R1: While reset is held, and for BUSY_CYCLES (default 2) clock cycles after it is released, the ready bit (status register, address 1, bit 0) reads 0. It reads 1 afterwards.
- R2: A write to address 0 is accepted only while ready is 1 and completion is 0. The clock edge that accepts it drops ready for exactly BUSY_CYCLES cycles.
- R3: A write to address 0 while ready is 0 is ignored: the byte counter does not change and no byte is emitted.
- R4: The byte counter reads at address 2 (bits 7:0) and address 3 (bits 15:8, with bits above 13 zero). It equals the number of accepted bytes and rises by one per accepted byte. Status bits 7:3 read 0.
- R5: The completion bit (status bit 1) becomes 1 in the cycle after the 10,496th byte is accepted. At that point the counter reads 10,496.
- R6: Once completion is 1, writes to address 0 are ignored. The counter, the completion bit and the checksum bit stay fixed until reset.
- R7: The checksum bit (status bit 2) reads 0 until completion. After completion it is 1 exactly when the CRC-16 over all 10,496 bytes (poly 0x1021, seed 0xFFFF, MSB first, no final inversion) is zero.
- R8: Each accepted byte appears on the stream output in the cycle after acceptance, with a one-cycle valid pulse and its zero-based index.
- R9: Reset clears the counter, both flags, the CRC and the stream valid, so that a new full load can follow.
- R10: Writes to addresses 1, 2 and 3 load nothing. Address 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 2 | Register select for read and write |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the selected register |
| cfg_valid_o | output | 1 | One-cycle pulse per accepted byte |
| cfg_byte_o | output | 8 | Accepted byte |
| cfg_index_o | output | 14 | Index of the accepted byte in the image |

## Verification
The sharpest coincidence is the write of the final byte. In that one edge the block must accept the byte, bump the counter to its limit, raise completion and settle the CRC verdict from the CRC value that includes that same byte. The host model issues every byte on the very first cycle that ready reads 1, so the final byte always lands on such a boundary. It then writes again once ready recovers after completion, where the same ready condition must now be overruled by the completion flag. A cycle-accurate behavioural reference runs in parallel and compares the status bits, the counter and the byte stream on every clock. Both a clean image and one with a corrupted byte are loaded.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    // register offsets
    localparam logic [ADDR_W-1:0] REG_DATA   = 2'd0;
    localparam logic [ADDR_W-1:0] REG_STAT   = 2'd1;
    localparam logic [ADDR_W-1:0] REG_CNT_LO = 2'd2;
    localparam logic [ADDR_W-1:0] REG_CNT_HI = 2'd3;

    // status bit positions
    localparam int STAT_READY = 0;
    localparam int STAT_DONE  = 1;
    localparam int STAT_PASS  = 2;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    // one byte of CRC-16, MSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in,
                                               input logic [BYTE_W-1:0] data);
        logic [15:0] r;
        r = crc_in ^ {data, 8'h00};
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[15]) r = {r[14:0], 1'b0} ^ CRC_POLY;
            else       r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_ldr_pace.sv
module cfg_ldr_pace #(
    parameter int BUSY_CYCLES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic accept_i,
    output logic ready_o
);
    localparam int WAIT_W = (BUSY_CYCLES < 1) ? 1 : $clog2(BUSY_CYCLES + 1);
    localparam logic [WAIT_W-1:0] BUSY_V = WAIT_W'(BUSY_CYCLES);

    typedef struct packed {
        logic [WAIT_W-1:0] wait_cnt;
    } pace_st_t;

    pace_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (accept_i) begin
            st_d.wait_cnt = BUSY_V;
        end else if (st_q.wait_cnt != '0) begin
            st_d.wait_cnt = st_q.wait_cnt - WAIT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{wait_cnt: BUSY_V};
        else         st_q <= st_d;
    end

    assign ready_o = (st_q.wait_cnt == '0);

endmodule

// File: rtl/cfg_ldr_core.sv
module cfg_ldr_core
    import cfg_ldr_pkg::*;
#(
    parameter int IMAGE_BYTES = 10496,
    parameter int CNT_W       = $clog2(IMAGE_BYTES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              accept_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic [CNT_W-1:0]  out_index_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(IMAGE_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [15:0]       crc;
        logic              done;
        logic              pass;
        logic              ov;
        logic [BYTE_W-1:0] ob;
        logic [CNT_W-1:0]  oi;
    } core_st_t;

    localparam core_st_t RST_ST = '{cnt: '0, crc: CRC_SEED, done: 1'b0,
                                    pass: 1'b0, ov: 1'b0, ob: '0, oi: '0};

    core_st_t    st_d, st_q;
    logic [15:0] crc_nx;

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        crc_nx  = crc16_step(st_q.crc, byte_i);
        if (accept_i) begin
            st_d.ov  = 1'b1;
            st_d.ob  = byte_i;
            st_d.oi  = st_q.cnt;
            st_d.crc = crc_nx;
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == LAST_IDX) begin
                st_d.done = 1'b1;
                st_d.pass = (crc_nx == 16'h0000);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RST_ST;
        else         st_q <= st_d;
    end

    assign count_o     = st_q.cnt;
    assign done_o      = st_q.done;
    assign pass_o      = st_q.pass;
    assign out_valid_o = st_q.ov;
    assign out_byte_o  = st_q.ob;
    assign out_index_o = st_q.oi;

endmodule

// File: rtl/cfg_ldr_regs.sv
module cfg_ldr_regs
    import cfg_ldr_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              ready_i,
    input  logic              done_i,
    input  logic              pass_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              accept_o,
    output logic [BYTE_W-1:0] rdata_o
);
    logic [2*BYTE_W-1:0] cnt_ext;
    logic [BYTE_W-1:0]   status;

    always_comb begin
        cnt_ext              = '0;
        cnt_ext[CNT_W-1:0]   = count_i;
        status               = '0;
        status[STAT_READY]   = ready_i;
        status[STAT_DONE]    = done_i;
        status[STAT_PASS]    = pass_i;
    end

    assign accept_o = wr_i && (addr_i == REG_DATA) && ready_i && !done_i;

    always_comb begin
        case (addr_i)
            REG_STAT:   rdata_o = status;
            REG_CNT_LO: rdata_o = cnt_ext[BYTE_W-1:0];
            REG_CNT_HI: rdata_o = cnt_ext[2*BYTE_W-1:BYTE_W];
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
    import cfg_ldr_pkg::*;
#(
    parameter int IMAGE_BYTES = 10496,
    parameter int BUSY_CYCLES = 2
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic [1:0]                         bus_addr_i,
    input  logic                               bus_wr_i,
    input  logic [7:0]                         bus_wdata_i,
    output logic [7:0]                         bus_rdata_o,
    output logic                               cfg_valid_o,
    output logic [7:0]                         cfg_byte_o,
    output logic [$clog2(IMAGE_BYTES+1)-1:0]   cfg_index_o
);
    localparam int CNT_W = $clog2(IMAGE_BYTES + 1);

    logic             accept_w;
    logic             ready_w;
    logic             done_w;
    logic             pass_w;
    logic [CNT_W-1:0] cnt_w;

    cfg_ldr_regs #(.CNT_W(CNT_W)) regs_i (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .ready_i  (ready_w),
        .done_i   (done_w),
        .pass_i   (pass_w),
        .count_i  (cnt_w),
        .accept_o (accept_w),
        .rdata_o  (bus_rdata_o)
    );

    cfg_ldr_pace #(.BUSY_CYCLES(BUSY_CYCLES)) pace_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .accept_i (accept_w),
        .ready_o  (ready_w)
    );

    cfg_ldr_core #(.IMAGE_BYTES(IMAGE_BYTES), .CNT_W(CNT_W)) core_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .accept_i    (accept_w),
        .byte_i      (bus_wdata_i),
        .count_o     (cnt_w),
        .done_o      (done_w),
        .pass_o      (pass_w),
        .out_valid_o (cfg_valid_o),
        .out_byte_o  (cfg_byte_o),
        .out_index_o (cfg_index_o)
    );

endmodule

// File: rtl/cfg_image_loader_chk.sv
module cfg_image_loader_chk #(
    parameter int IMAGE_BYTES = 10496,
    parameter int BUSY_CYCLES = 2,
    parameter int CNT_W       = $clog2(IMAGE_BYTES + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       addr_i,
    input logic             wr_i,
    input logic             ready_i,
    input logic             done_i,
    input logic             pass_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             ov_i,
    input logic [CNT_W-1:0] oi_i
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(IMAGE_BYTES);

    logic acc;
    assign acc = wr_i && (addr_i == 2'd0) && ready_i && !done_i;

    // R2
    p_ready_drops_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> ((BUSY_CYCLES == 0) || !ready_i));

    // R3
    p_busy_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !ready_i) |=> $stable(cnt_i));

    // R4
    p_count_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cnt_i) |-> (cnt_i == $past(cnt_i) + CNT_W'(1)));

    // R5
    p_done_at_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> (cnt_i == FULL));

    // R6
    p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> (done_i && $stable(cnt_i) && $stable(pass_i)));

    // R7
    p_pass_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_i |-> done_i);

    // R8
    p_stream_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> (ov_i && (oi_i == $past(cnt_i))));

    // R10
    p_other_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && (addr_i != 2'd0)) |=> $stable(cnt_i));

endmodule

bind cfg_image_loader cfg_image_loader_chk #(
    .IMAGE_BYTES (IMAGE_BYTES),
    .BUSY_CYCLES (BUSY_CYCLES)
) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .ready_i (ready_w),
    .done_i  (done_w),
    .pass_i  (pass_w),
    .cnt_i   (cnt_w),
    .ov_i    (cfg_valid_o),
    .oi_i    (cfg_index_o)
);

// File: tb/cfg_image_loader_tb_top.sv
module cfg_image_loader_tb_top;
    localparam int IMG  = 10496;
    localparam int BUSY = 2;
    localparam int CW   = 14;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b1;
    logic [1:0]    addr  = 2'd1;
    logic          wr    = 1'b0;
    logic [7:0]    wdata = 8'h00;
    wire  [7:0]    rdata;
    wire           ov;
    wire  [7:0]    ob;
    wire  [CW-1:0] oi;

    cfg_image_loader #(.IMAGE_BYTES(IMG), .BUSY_CYCLES(BUSY)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cfg_valid_o(ov),
        .cfg_byte_o(ob), .cfg_index_o(oi)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [7:0] img [IMG];

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        int acc;
        acc = c;
        for (int b = 7; b >= 0; b--) begin
            int fb;
            fb  = ((acc >> 15) & 1) ^ ((d >> b) & 1);
            acc = (acc << 1) & 16'hFFFF;
            if (fb != 0) acc = acc ^ 16'h1021;
        end
        return acc[15:0];
    endfunction

    // behavioural reference
    int         m_wait = BUSY;
    int         m_cnt  = 0;
    logic [15:0] m_crc = 16'hFFFF;
    bit         m_done = 0;
    bit         m_ok   = 0;
    bit         m_ov   = 0;
    logic [7:0] m_ob   = 0;
    int         m_oi   = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_wait = BUSY; m_cnt = 0; m_crc = 16'hFFFF;
            m_done = 0; m_ok = 0; m_ov = 0;
        end else begin
            bit acc;
            acc  = wr && (addr == 2'd0) && (m_wait == 0) && !m_done;
            m_ov = acc;
            if (acc) begin
                m_ob  = wdata;
                m_oi  = m_cnt;
                m_crc = ref_crc(m_crc, wdata);
                m_cnt++;
                if (m_cnt == IMG) begin
                    m_done = 1;
                    m_ok   = (m_crc == 16'h0000);
                end
                m_wait = BUSY;
            end else if (m_wait > 0) begin
                m_wait--;
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        case (addr)
            2'd0: chk("R10 data register reads zero", int'(rdata), 0);
            2'd1: begin
                chk("R2 ready bit", int'(rdata[0]), int'(m_wait == 0));
                chk("R5 complete bit", int'(rdata[1]), int'(m_done));
                chk("R7 checksum bit", int'(rdata[2]), int'(m_ok));
                chk("R4 status spare bits", int'(rdata[7:3]), 0);
            end
            2'd2: chk("R4 counter low byte", int'(rdata), m_cnt & 255);
            default: chk("R4 counter high byte", int'(rdata), m_cnt >> 8);
        endcase
        chk("R8 stream valid", int'(ov), int'(m_ov));
        if (m_ov) begin
            chk("R8 stream byte", int'(ob), int'(m_ob));
            chk("R8 stream index", int'(oi), m_oi);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // all tasks start and end just after a falling edge
    task automatic read_reg(input logic [1:0] a, output logic [7:0] v);
        addr = a; wr = 1'b0;
        @(negedge clk);
        v = rdata;
        #1;
    endtask

    task automatic write_byte(input logic [7:0] b, input bit stray);
        bit seen;
        seen = 0;
        addr = 2'd1; wr = 1'b0;
        for (int n = 0; n < 50 && !seen; n++) begin
            @(negedge clk);
            seen = rdata[0];
        end
        if (!seen) chk("R2 ready never returned", 0, 1);
        #1;
        addr = 2'd0; wr = 1'b1; wdata = b;
        @(negedge clk); #1;
        if (stray) begin
            wdata = ~b;
            @(negedge clk); #1;
        end
        wr = 1'b0; addr = 2'd1;
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0; wr = 1'b0; addr = 2'd1;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic load_all();
        for (int i = 0; i < IMG; i++) write_byte(img[i], (i % 97) == 5);
    endtask

    initial begin
        logic [7:0]  v;
        logic [15:0] c;
        for (int i = 0; i < IMG - 2; i++) img[i] = 8'((i * 37) ^ (i >> 5));
        c = 16'hFFFF;
        for (int i = 0; i < IMG - 2; i++) c = ref_crc(c, img[i]);
        img[IMG-2] = c[15:8];
        img[IMG-1] = c[7:0];

        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 status during reset", int'(rdata), 0);
        #1 rst_n = 1'b1;
        // first cycle after release: ready still low; a data write is dropped
        addr = 2'd0; wr = 1'b1; wdata = 8'hA5;
        @(negedge clk); #1;
        wr = 1'b0;
        read_reg(2'd1, v);
        chk("R1 ready after busy interval", int'(v[0]), 1);
        read_reg(2'd2, v);
        chk("R3 early write ignored", int'(v), 0);

        // writes to non-data addresses while ready
        for (int a = 1; a < 4; a++) begin
            addr = 2'(a); wr = 1'b1; wdata = 8'h3C;
            @(negedge clk); #1;
        end
        wr = 1'b0;
        read_reg(2'd2, v);
        chk("R10 other-address writes load nothing", int'(v), 0);

        // partial load then reset
        for (int i = 0; i < 100; i++) write_byte(img[i], i == 7);
        read_reg(2'd2, v);
        chk("R4 partial count low", int'(v), 100);
        read_reg(2'd3, v);
        chk("R4 partial count high", int'(v), 0);
        pulse_reset();
        read_reg(2'd2, v);
        chk("R9 counter cleared by reset", int'(v), 0);
        read_reg(2'd1, v);
        chk("R9 flags cleared by reset", int'(v[2:1]), 0);

        // clean full load
        load_all();
        read_reg(2'd1, v);
        chk("R5 complete after full image", int'(v[1]), 1);
        chk("R7 checksum passes on clean image", int'(v[2]), 1);
        write_byte(8'h77, 1'b0);
        write_byte(8'h78, 1'b0);
        read_reg(2'd2, v);
        chk("R6 count low held after complete", int'(v), 8'h00);
        read_reg(2'd3, v);
        chk("R6 count high held after complete", int'(v), 8'h29);
        read_reg(2'd1, v);
        chk("R6 flags held after complete", int'(v[2:1]), 3);

        // corrupted image
        pulse_reset();
        img[5000] = img[5000] ^ 8'h10;
        load_all();
        read_reg(2'd1, v);
        chk("R5 complete after corrupted image", int'(v[1]), 1);
        chk("R7 checksum fails on corrupted image", int'(v[2]), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule